// File: doc/BRIEF.md
# Stack Frame Entry and Exit Sequencer

This block carries out function prologue and epilogue frame handling for a 32-bit core in which R14 serves as the frame pointer and R15 as the stack pointer. The core presents an instruction (opcode byte, four-bit sub-code and 8-bit immediate) together with the current frame and stack pointer values on a one-cycle `issue` strobe. The block then performs one memory access through a single read/write port and finishes with a write-back of both pointers on a `done` pulse.

On entry, the old frame pointer is stored in the word just below the stack pointer. The frame pointer then moves to that slot, and the stack pointer drops by a local-area size. The immediate gives that size in words, so the byte amount is the immediate times four. On exit, the stack pointer is rebuilt as the frame pointer plus four, and the frame pointer is reloaded from the word at the old frame pointer. All arithmetic uses the pointer values sampled on the issue cycle and wraps modulo 2^32.

The sequencer has three named states. IDLE waits for a recognised opcode, and the transition IDLE->ACCESS latches the operands. ACCESS holds the memory request until ready is seen, and the transition ACCESS->COMMIT captures read data. COMMIT drives both write-backs and `done` for one cycle, and the transition COMMIT->IDLE follows unconditionally. ACCESS stays in ACCESS while ready is low.

Top module: `frame_seq`

## Requirements
- R1: An issue with `op_byte` 0x0F is an entry (the sub-code is ignored), and an issue with `op_byte` 0x9F and `sub_code` 9 is an exit. Any other code produces no memory request, no write enable and no `done`.
- R2: For an entry, the memory request has `mem_wr`=1, `mem_addr` = sampled R15 - 4 and `mem_wdata` = sampled R14.
- R3: At entry write-back, `fp_wdata` = sampled R15 - 4 and `sp_wdata` = sampled R15 - 4*imm8. An imm8 of 0 leaves R15 at its sampled value and still saves R14.
- R4: For an exit, the memory request has `mem_wr`=0 and `mem_addr` = sampled R14, which is the new R15 minus 4.
- R5: At exit write-back, `sp_wdata` = sampled R14 + 4 and `fp_wdata` = the `mem_rdata` presented with `mem_ready`.
- R6: `mem_req` is high in the first cycle after the issue cycle. `fp_we`, `sp_we` and `done` are high together for exactly one cycle, the cycle after the one in which `mem_req` and `mem_ready` are both high. In the cycle after that, `mem_req` is low.
- R7: While `mem_ready` is low, `mem_req`, `mem_addr` and `mem_wr` hold steady and no write enable or `done` is asserted.
- R8: All address and pointer arithmetic wraps modulo 2^32.
- R9: Changes on `fp_in`, `sp_in` and `imm8` after the issue cycle have no effect on the access or the write-back.
- R10: An `issue` while an instruction is in progress is ignored: the ongoing operation completes unchanged and no further request follows.
- R11: During and right after reset, `mem_req`, `fp_we`, `sp_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction presented this cycle |
| op_byte | input | 8 | Primary opcode |
| sub_code | input | 4 | Extended sub-code |
| imm8 | input | 8 | Frame size in words |
| fp_in | input | 32 | Current R14 |
| sp_in | input | 32 | Current R15 |
| fp_we | output | 1 | R14 write enable |
| fp_wdata | output | 32 | New R14 |
| sp_we | output | 1 | R15 write enable |
| sp_wdata | output | 32 | New R15 |
| mem_req | output | 1 | Memory access request |
| mem_wr | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with ready |
| mem_ready | input | 1 | Access completes this cycle |
| done | output | 1 | Instruction finished, write-back this cycle |

## Verification
The request is due one cycle after the issue edge. The write-back and `done` are due exactly one cycle after the edge at which ready was sampled high, and the request drops one cycle after that. The bench drives every input on the falling edge and samples at the next falling edge, so each check lands in the single cycle where a result is owed. Wait states of random length are inserted before ready, and in every wait cycle the bench confirms that the request and address are held and that no write enable is present. The pointer inputs are scrambled right after issue, so any use of live values instead of sampled values shows up as a mismatch.

// File: rtl/frame_pkg.sv
package frame_pkg;
    localparam logic [7:0] OPC_ENTRY = 8'h0F;
    localparam logic [7:0] OPC_EXTENDED = 8'h9F;
    localparam logic [3:0] SUB_EXIT = 4'h9;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_ENTRY = 2'd1,
        KIND_EXIT  = 2'd2
    } frame_kind_t;
endpackage

// File: rtl/frame_decode.sv
module frame_decode
    import frame_pkg::*;
(
    input  logic [7:0]  op_byte,
    input  logic [3:0]  sub_code,
    output frame_kind_t kind
);
    always_comb begin
        kind = KIND_NONE;
        if (op_byte == OPC_ENTRY) begin
            kind = KIND_ENTRY;
        end else if (op_byte == OPC_EXTENDED && sub_code == SUB_EXIT) begin
            kind = KIND_EXIT;
        end
    end
endmodule

// File: rtl/frame_addr.sv
module frame_addr
    import frame_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int IMM_W    = 8,
    parameter int SCALE_SH = 2
) (
    input  frame_kind_t       kind,
    input  logic [XLEN-1:0]   fp_base,
    input  logic [XLEN-1:0]   sp_base,
    input  logic [IMM_W-1:0]  size_words,
    input  logic [XLEN-1:0]   load_data,
    output logic [XLEN-1:0]   acc_addr,
    output logic [XLEN-1:0]   acc_wdata,
    output logic [XLEN-1:0]   fp_next,
    output logic [XLEN-1:0]   sp_next
);
    localparam int PAD = XLEN - IMM_W - SCALE_SH;
    localparam logic [XLEN-1:0] WORD = XLEN'(XLEN / 8);

    logic [XLEN-1:0] scaled;
    logic [XLEN-1:0] save_slot;
    logic [XLEN-1:0] restored_sp;

    assign scaled      = {{PAD{1'b0}}, size_words, {SCALE_SH{1'b0}}};
    assign save_slot   = sp_base - WORD;
    assign restored_sp = fp_base + WORD;

    always_comb begin
        acc_addr  = '0;
        acc_wdata = '0;
        fp_next   = fp_base;
        sp_next   = sp_base;
        unique case (kind)
            KIND_ENTRY: begin
                acc_addr  = save_slot;
                acc_wdata = fp_base;
                fp_next   = save_slot;
                sp_next   = sp_base - scaled;
            end
            KIND_EXIT: begin
                acc_addr  = restored_sp - WORD;
                fp_next   = load_data;
                sp_next   = restored_sp;
            end
            default: begin
                acc_addr  = '0;
            end
        endcase
    end
endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
    import frame_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_ok,
    input  logic       mem_ready,
    output seq_state_t state,
    output logic       capture,
    output logic       access,
    output logic       commit
);
    seq_state_t state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start_ok) state_nx = ST_ACCESS;
            ST_ACCESS: if (mem_ready) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        capture = 1'b0;
        access  = 1'b0;
        commit  = 1'b0;
        unique case (state)
            ST_IDLE:   capture = start_ok;
            ST_ACCESS: access  = 1'b1;
            ST_COMMIT: commit  = 1'b1;
            default:   commit  = 1'b0;
        endcase
    end

    p_commit_after_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(access && mem_ready));
    p_single_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit && !access);
    p_access_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !mem_ready) |=> access);
endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import frame_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int IMM_W    = 8,
    parameter int SCALE_SH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [7:0]       op_byte,
    input  logic [3:0]       sub_code,
    input  logic [IMM_W-1:0] imm8,
    input  logic [XLEN-1:0]  fp_in,
    input  logic [XLEN-1:0]  sp_in,
    output logic             fp_we,
    output logic [XLEN-1:0]  fp_wdata,
    output logic             sp_we,
    output logic [XLEN-1:0]  sp_wdata,
    output logic             mem_req,
    output logic             mem_wr,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic             mem_ready,
    output logic             done
);
    localparam logic [XLEN-1:0] WORD = XLEN'(XLEN / 8);

    frame_kind_t      dec_kind;
    frame_kind_t      kind_q;
    seq_state_t       state;
    logic             capture;
    logic             access;
    logic             commit;
    logic [XLEN-1:0]  fp_q;
    logic [XLEN-1:0]  sp_q;
    logic [IMM_W-1:0] imm_q;
    logic [XLEN-1:0]  load_q;
    logic [XLEN-1:0]  fp_next;
    logic [XLEN-1:0]  sp_next;

    frame_decode u_decode (
        .op_byte  (op_byte),
        .sub_code (sub_code),
        .kind     (dec_kind)
    );

    frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ok  (issue && (dec_kind != KIND_NONE)),
        .mem_ready (mem_ready),
        .state     (state),
        .capture   (capture),
        .access    (access),
        .commit    (commit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= KIND_NONE;
            fp_q   <= '0;
            sp_q   <= '0;
            imm_q  <= '0;
            load_q <= '0;
        end else begin
            if (capture) begin
                kind_q <= dec_kind;
                fp_q   <= fp_in;
                sp_q   <= sp_in;
                imm_q  <= imm8;
            end
            if (access && mem_ready) begin
                load_q <= mem_rdata;
            end
        end
    end

    frame_addr #(
        .XLEN     (XLEN),
        .IMM_W    (IMM_W),
        .SCALE_SH (SCALE_SH)
    ) u_addr (
        .kind       (kind_q),
        .fp_base    (fp_q),
        .sp_base    (sp_q),
        .size_words (imm_q),
        .load_data  (load_q),
        .acc_addr   (mem_addr),
        .acc_wdata  (mem_wdata),
        .fp_next    (fp_next),
        .sp_next    (sp_next)
    );

    assign mem_req  = access;
    assign mem_wr   = access && (kind_q == KIND_ENTRY);
    assign fp_we    = commit;
    assign sp_we    = commit;
    assign done     = commit;
    assign fp_wdata = fp_next;
    assign sp_wdata = sp_next;

    p_entry_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_we && kind_q == KIND_ENTRY) |-> fp_wdata == $past(mem_addr));
    p_exit_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_we && kind_q == KIND_EXIT) |-> fp_wdata == $past(mem_rdata));
    p_exit_sp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_we && kind_q == KIND_EXIT) |-> sp_wdata == $past(mem_addr) + WORD);
    p_stall_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_wr) && !fp_we);
    p_ignored_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && !done && issue && dec_kind == KIND_NONE) |=> !mem_req);
    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> !mem_req && !done);
endmodule

// File: tb/frame_seq_bench.sv
module frame_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [7:0]  op_byte = 8'h00;
    logic [3:0]  sub_code = 4'h0;
    logic [7:0]  imm8 = 8'h00;
    logic [31:0] fp_in = '0;
    logic [31:0] sp_in = '0;
    logic        fp_we;
    logic [31:0] fp_wdata;
    logic        sp_we;
    logic [31:0] sp_wdata;
    logic        mem_req;
    logic        mem_wr;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        done;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    frame_seq u_frame_seq (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op_byte(op_byte),
        .sub_code(sub_code), .imm8(imm8), .fp_in(fp_in), .sp_in(sp_in),
        .fp_we(fp_we), .fp_wdata(fp_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
        .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .done(done)
    );

    function automatic logic [31:0] exp_addr(bit ent, logic [31:0] fp, logic [31:0] sp);
        return ent ? sp - 32'd4 : fp;
    endfunction

    function automatic logic [31:0] exp_fp(bit ent, logic [31:0] sp, logic [31:0] rd);
        return ent ? sp - 32'd4 : rd;
    endfunction

    function automatic logic [31:0] exp_sp(bit ent, logic [31:0] fp, logic [31:0] sp,
                                           logic [7:0] imm);
        return ent ? sp - {22'd0, imm, 2'b00} : fp + 32'd4;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(bit ent, logic [31:0] fp, logic [31:0] sp, logic [7:0] imm,
                          logic [31:0] rd, int waits, bit poke, string tag);
        logic [31:0] ea;
        ea = exp_addr(ent, fp, sp);
        @(negedge clk);
        issue    = 1'b1;
        op_byte  = ent ? 8'h0F : 8'h9F;
        sub_code = ent ? 4'($urandom) : 4'h9;
        imm8     = imm;
        fp_in    = fp;
        sp_in    = sp;
        @(negedge clk);
        issue    = poke;
        op_byte  = ent ? 8'h9F : 8'h0F;
        sub_code = 4'h9;
        imm8     = ~imm;
        fp_in    = ~fp;
        sp_in    = sp ^ 32'h5A5A_A5A5;
        check(mem_req == 1'b1, "R6 request after issue", 32'(mem_req), 32'd1);
        check(mem_addr == ea, ent ? "R2 entry address" : "R4 exit address", mem_addr, ea);
        check(mem_wr == ent, ent ? "R2 write dir" : "R4 read dir", 32'(mem_wr), 32'(ent));
        if (ent) check(mem_wdata == fp, "R2 saved fp", mem_wdata, fp);
        for (int i = 0; i < waits; i++) begin
            mem_ready = 1'b0;
            check(!fp_we && !sp_we && !done, "R7 no write-back in stall", 32'(fp_we), 32'd0);
            @(negedge clk);
            check(mem_req && mem_addr == ea && mem_wr == ent, "R7 held request", mem_addr, ea);
        end
        mem_ready = 1'b1;
        mem_rdata = rd;
        @(negedge clk);
        mem_ready = 1'b0;
        mem_rdata = ~rd;
        issue     = 1'b0;
        check(done && fp_we && sp_we, "R6 done with write-back", 32'(done), 32'd1);
        check(fp_wdata == exp_fp(ent, sp, rd), {tag, ent ? " R3 new fp" : " R5 new fp"},
              fp_wdata, exp_fp(ent, sp, rd));
        check(sp_wdata == exp_sp(ent, fp, sp, imm), {tag, ent ? " R3 new sp" : " R5 new sp"},
              sp_wdata, exp_sp(ent, fp, sp, imm));
        @(negedge clk);
        check(!done && !fp_we && !mem_req, poke ? "R10 busy issue ignored" : "R6 one-cycle done",
              32'(mem_req), 32'd0);
    endtask

    task automatic run_bad(logic [7:0] op, logic [3:0] sub);
        @(negedge clk);
        issue    = 1'b1;
        op_byte  = op;
        sub_code = sub;
        @(negedge clk);
        issue = 1'b0;
        check(!mem_req, "R1 unknown code no request", 32'(mem_req), 32'd0);
        @(negedge clk);
        check(!done && !fp_we && !sp_we && !mem_req, "R1 unknown code no write-back",
              32'(done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!mem_req && !done && !fp_we && !sp_we, "R11 quiet in reset", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req && !done && !fp_we && !sp_we, "R11 quiet after reset", 32'(done), 32'd0);

        run_op(1'b1, 32'h0000_2000, 32'h0000_1F00, 8'h04, 32'h0, 0, 1'b0, "entry basic");
        run_op(1'b0, 32'h0000_1EFC, 32'h0000_1EEC, 8'h00, 32'h0000_2000, 0, 1'b0, "exit basic");
        run_op(1'b1, 32'h1234_5678, 32'h0000_8000, 8'h00, 32'h0, 2, 1'b0, "R3 zero frame");
        run_op(1'b1, 32'hAAAA_0000, 32'h0000_0000, 8'hFF, 32'h0, 1, 1'b0, "R8 wrap entry");
        run_op(1'b0, 32'hFFFF_FFFC, 32'h0000_0100, 8'h11, 32'hCAFE_F00D, 3, 1'b0, "R8 wrap exit");
        run_op(1'b1, 32'h0000_4000, 32'h0000_3000, 8'h80, 32'h0, 2, 1'b1, "R10 busy entry");
        run_op(1'b0, 32'h0000_5000, 32'h0000_4000, 8'h22, 32'h0BAD_BEEF, 1, 1'b1, "R10 busy exit");
        run_bad(8'h9F, 4'h8);
        run_bad(8'h0E, 4'h9);
        run_bad(8'h8F, 4'h9);

        for (int n = 0; n < 40; n++) begin
            run_op(1'($urandom), $urandom, $urandom, 8'($urandom), $urandom,
                   int'($urandom % 4), 1'($urandom), "R9 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule